// File: doc/BRIEF.md
# Runtime-Format Serial Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A client offers a character with a valid/ready handshake. The block accepts it only when it is enabled and idle, then drives the whole frame and holds a busy flag until the frame ends. Every frame starts with a low start bit, and the data bits follow least significant bit first. After the data come an optional parity bit and one or two high stop bits. Between frames the line rests high.

Four mode inputs set the frame shape at run time: character length, parity on or off, parity sense, and stop-bit count. The block copies them into an internal format register only while it is disabled and idle. Changing them at any other time has no effect, so the shape of a frame cannot change partway through. Bit timing comes from an external tick enable that runs at a fixed multiple (sixteen by default) of the bit rate. Baud generation is left to the surrounding logic.

Top module: `uart_fmt_tx`

## Requirements
- R1: After a character is accepted, `txd` is driven low for exactly one bit period (the start bit), beginning the cycle after the accepting clock edge.
- R2: With the latched length select `fmt_len8` = 0, exactly 7 data bits (tx_data[6:0]) are sent. With `fmt_len8` = 1, exactly 8 data bits (tx_data[7:0]) are sent.
- R3: Data bits follow the start bit least significant bit first, with bit 0 immediately after the start bit.
- R4: With the latched `fmt_par_en` = 1, one parity bit is sent after the last data bit and before the stop bits. With `fmt_par_en` = 0, no parity bit is sent.
- R5: The parity bit covers only the active data bits, so bit 7 is excluded in 7-bit mode. `fmt_par_odd` = 0 makes the count of ones over data plus parity even, and 1 makes it odd.
- R6: The stop bits are high. The latched `fmt_stop2` = 0 sends one stop bit and 1 sends two.
- R7: Each bit lasts exactly TICKS_PER_BIT (default 16) clock edges at which `tick16` is high, counted from the accepting edge. Edges with `tick16` low do not advance the frame.
- R8: `tx_ready` is high exactly when `en` is high and `busy` is low. A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and is never accepted otherwise.
- R9: `busy` rises on the accepting edge and falls on the edge that completes the last stop bit. While `busy` is low, and during reset, `txd` is high.
- R10: The four mode inputs are latched into the format register on every edge where `en` is low and `busy` is low, and at no other time. Mode changes made while enabled or busy do not alter the frame in progress or later frames. After reset the format is 7 bits, no parity, even sense, one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low opens the format latch |
| tick16 | input | 1 | Sampling tick, TICKS_PER_BIT per bit period |
| fmt_len8 | input | 1 | 0: 7 data bits, 1: 8 data bits |
| fmt_par_en | input | 1 | 1: append a parity bit |
| fmt_par_odd | input | 1 | 0: even parity, 1: odd parity |
| fmt_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| tx_data | input | MAX_DATA | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Character can be accepted this cycle |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The bench drives all sixteen format combinations with random characters and irregular tick spacing, and compares the line against a model of the frame on every cycle. It targets 7-bit characters whose bit 7 is set: a design that folds bit 7 into the parity would send the wrong parity bit, and one that sends it would stretch the frame. It keeps `tx_valid` high through a whole frame and toggles the mode inputs, and sometimes drops `en`, while a frame is in flight. A leaky handshake would start a second frame early, and an unguarded format latch would reshape the current or the next frame. Gaps in the tick stream catch a bit counter that runs on the clock instead of the tick.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

   // Latched frame-shape controls
   typedef struct packed {
      logic len8;     // 1: eight data bits, 0: seven
      logic par_en;   // 1: parity bit present
      logic par_odd;  // 1: odd parity, 0: even
      logic stop2;    // 1: two stop bits
   } fmt_t;

endpackage

// File: rtl/uart_fmt_cfg.sv
module uart_fmt_cfg
   import uart_fmt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic busy,
   input  fmt_t fmt_in,
   output fmt_t fmt_q
);

   // The format register follows the inputs only while disabled and idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= '0;
      end else if (!en && !busy) begin
         fmt_q <= fmt_in;
      end
   end

endmodule

// File: rtl/uart_fmt_framer.sv
module uart_fmt_framer
   import uart_fmt_pkg::*;
#(
   parameter int MAX_DATA = 8,
   parameter int FRAME_W  = MAX_DATA + 4,
   parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
   input  fmt_t                fmt,
   input  logic [MAX_DATA-1:0] data,
   output logic [FRAME_W-1:0]  frame,
   output logic [CNT_W-1:0]    nbits
);

   localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(MAX_DATA);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(MAX_DATA - 1);

   logic [CNT_W-1:0]    dlen;
   logic [CNT_W-1:0]    par_pos;
   logic [MAX_DATA-1:0] active;
   logic                par_bit;

   always_comb begin
      dlen    = fmt.len8 ? LEN_LONG : LEN_SHORT;
      par_pos = dlen + CNT_W'(1);
      active  = data;
      if (!fmt.len8) begin
         active[MAX_DATA-1] = 1'b0;
      end
      par_bit = (^active) ^ fmt.par_odd;

      // Frame is built least significant first; unused slots stay high.
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (fmt.len8 || (i < MAX_DATA - 1)) begin
            frame[i+1] = data[i];
         end
      end
      if (fmt.par_en) begin
         frame[par_pos] = par_bit;
      end

      nbits = dlen + CNT_W'(2) + CNT_W'(fmt.par_en) + CNT_W'(fmt.stop2);
   end

endmodule

// File: rtl/uart_fmt_bitclk.sv
module uart_fmt_bitclk #(
   parameter int TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic bit_done
);

   localparam int               TW   = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam bit               POW2 = ((TICKS & (TICKS - 1)) == 0);
   localparam logic [TW-1:0]    LAST = TW'(TICKS - 1);

   logic [TW-1:0] cnt_q;

   assign bit_done = tick && (cnt_q == LAST);

   generate
      if (POW2) begin : g_wrap
         // Natural wrap of the counter marks the bit boundary.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear) begin
               cnt_q <= '0;
            end else if (tick) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear) begin
               cnt_q <= '0;
            end else if (tick) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
   import uart_fmt_pkg::*;
#(
   parameter int MAX_DATA      = 8,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick16,
   input  logic                fmt_len8,
   input  logic                fmt_par_en,
   input  logic                fmt_par_odd,
   input  logic                fmt_stop2,
   input  logic [MAX_DATA-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic                txd,
   output logic                busy
);

   localparam int FRAME_W = MAX_DATA + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (MAX_DATA < 2) begin : g_bad_data
         $error("uart_fmt_tx: MAX_DATA must be at least 2");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("uart_fmt_tx: TICKS_PER_BIT must be at least 2");
      end
   endgenerate

   fmt_t               fmt_in;
   fmt_t               fmt_q;
   logic [FRAME_W-1:0] frame_w;
   logic [CNT_W-1:0]   nbits_w;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   left_q;
   logic               busy_q;
   logic               load;
   logic               bit_done;

   assign fmt_in = '{len8: fmt_len8, par_en: fmt_par_en,
                     par_odd: fmt_par_odd, stop2: fmt_stop2};

   assign tx_ready = en && !busy_q;
   assign load     = tx_valid && tx_ready;
   assign busy     = busy_q;
   assign txd      = busy_q ? shreg_q[0] : 1'b1;

   uart_fmt_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .busy   (busy_q),
      .fmt_in (fmt_in),
      .fmt_q  (fmt_q)
   );

   uart_fmt_framer #(
      .MAX_DATA (MAX_DATA),
      .FRAME_W  (FRAME_W),
      .CNT_W    (CNT_W)
   ) u_framer (
      .fmt   (fmt_q),
      .data  (tx_data),
      .frame (frame_w),
      .nbits (nbits_w)
   );

   uart_fmt_bitclk #(
      .TICKS (TICKS_PER_BIT)
   ) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (load),
      .tick     (tick16),
      .bit_done (bit_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
         left_q  <= '0;
         busy_q  <= 1'b0;
      end else if (load) begin
         shreg_q <= frame_w;
         left_q  <= nbits_w;
         busy_q  <= 1'b1;
      end else if (busy_q && bit_done) begin
         shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
         left_q  <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/uart_fmt_tx_chk.sv
module uart_fmt_tx_chk
   import uart_fmt_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic tick16,
   input logic tx_valid,
   input logic tx_ready,
   input logic txd,
   input logic busy,
   input fmt_t fmt_q
);

   p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);

   p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd));

   p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick16) |=> (busy && $stable(txd)));

   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> busy);

   p_no_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !tx_ready);

   p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   p_fmt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) || $past(busy)) |-> $stable(fmt_q));

endmodule

bind uart_fmt_tx uart_fmt_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .tick16   (tick16),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .txd      (txd),
   .busy     (busy),
   .fmt_q    (fmt_q)
);

// File: tb/tb_uart_fmt_tx.sv
module tb_uart_fmt_tx;

   localparam int CLK_PERIOD = 10;
   localparam int TPB        = 16;
   localparam int WDOG       = 150000;

   logic       clk;
   logic       rst_n;
   logic       en_a, tick_a, valid_a;
   logic [3:0] mode_a;   // {len8, par_en, par_odd, stop2}
   logic [7:0] data_a;
   logic       tx_ready, txd, busy;

   int checks = 0;
   int fails  = 0;
   bit tick_mode = 0;

   // reference model state
   bit         m_busy = 0;
   logic [11:0] m_frame = '1;
   int         m_n = 0, m_ticks = 0, m_dl = 7;
   bit         m_par = 0, m_pk = 0;
   logic [3:0] m_fmt = 4'b0000;

   uart_fmt_tx dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en_a),
      .tick16      (tick_a),
      .fmt_len8    (mode_a[3]),
      .fmt_par_en  (mode_a[2]),
      .fmt_par_odd (mode_a[1]),
      .fmt_stop2   (mode_a[0]),
      .tx_data     (data_a),
      .tx_valid    (valid_a),
      .tx_ready    (tx_ready),
      .txd         (txd),
      .busy        (busy)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [11:0] exp_frame(logic [3:0] f, logic [7:0] d);
      logic [11:0] r = '1;
      logic p = 1'b0;
      int dl = f[3] ? 8 : 7;
      r[0] = 1'b0;
      for (int i = 0; i < dl; i++) begin
         r[i+1] = d[i];
         p = p ^ d[i];
      end
      if (f[2]) r[dl+1] = p ^ f[1];
      return r;
   endfunction

   function automatic int exp_len(logic [3:0] f);
      return 1 + (f[3] ? 8 : 7) + int'(f[2]) + 1 + int'(f[0]);
   endfunction

   function automatic string bit_tag();
      string t;
      int idx = m_ticks / TPB;
      if (!m_busy) return "R9";
      if (idx == 0)                       t = "R1 R7";
      else if (idx <= m_dl)               t = "R2 R3 R7";
      else if (m_par && idx == m_dl + 1)  t = "R4 R5 R7";
      else                                t = "R6 R4 R7";
      if (m_pk) t = {t, " R10"};
      return t;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic model_step();
      bit was_busy = m_busy;
      if (!was_busy && en_a && valid_a) begin
         m_frame = exp_frame(m_fmt, data_a);
         m_n     = exp_len(m_fmt);
         m_dl    = m_fmt[3] ? 8 : 7;
         m_par   = m_fmt[2];
         m_busy  = 1;
         m_ticks = 0;
         m_pk    = 0;
      end else if (was_busy && tick_a) begin
         m_ticks++;
         if (m_ticks == TPB * m_n) m_busy = 0;
      end
      // R10: latch only while disabled and idle
      if (!en_a && !was_busy) m_fmt = mode_a;
   endtask

   task automatic cycle();
      logic exp_txd;
      @(negedge clk);
      if (rst_n) model_step();
      exp_txd = m_busy ? m_frame[m_ticks / TPB] : 1'b1;
      chk(bit_tag(), txd, exp_txd);
      chk("R9 busy", busy, m_busy);
      chk("R8 ready", tx_ready, en_a && !m_busy);
      tick_a = tick_mode ? (($urandom % 4) != 0) : 1'b1;
   endtask

   task automatic send(logic [3:0] f, logic [7:0] d, bit hold_valid,
                       bit poke, bit drop_en);
      int n = 0;
      en_a   = 1'b0;
      mode_a = f;
      cycle();
      cycle();
      en_a    = 1'b1;
      data_a  = d;
      valid_a = 1'b1;
      do cycle(); while (!m_busy);
      valid_a = hold_valid;   // R8: must not start a second frame
      data_a  = ~d;
      while (m_busy) begin
         n++;
         if (poke && n == 20) begin
            mode_a = ~f;      // R10: ignored while busy
            m_pk   = 1;
         end
         if (drop_en && n == 40) en_a = 1'b0;
         cycle();
      end
      valid_a = 1'b0;
      cycle();
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog: busy actual=%b expected=0", busy);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h0000_5A17));
      rst_n   = 1'b0;
      en_a    = 1'b0;
      tick_a  = 1'b1;
      valid_a = 1'b0;
      mode_a  = 4'b0000;
      data_a  = 8'h00;
      repeat (4) cycle();   // reset state: txd high, busy low (R9)
      rst_n = 1'b1;

      // R8: offered while disabled is never accepted
      valid_a = 1'b1;
      data_a  = 8'h55;
      repeat (6) cycle();
      valid_a = 1'b0;
      cycle();

      // directed corners (R2 R5: bit 7 excluded in 7-bit mode)
      send(4'b0100, 8'h80, 0, 0, 0);
      send(4'b0100, 8'hFF, 0, 0, 0);
      send(4'b0110, 8'h7F, 1, 0, 0);
      send(4'b1111, 8'hA5, 1, 1, 0);
      send(4'b1000, 8'h3C, 0, 1, 1);
      send(4'b0001, 8'hC3, 0, 0, 0);

      // random formats, data and tick spacing
      tick_mode = 1;
      for (int k = 0; k < 40; k++) begin
         send(4'($urandom), 8'($urandom), ($urandom % 2) == 1,
              ($urandom % 3) == 0, ($urandom % 4) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule